// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a small 32-bit processor that retires exactly one instruction on every rising clock edge. A fetched word is decoded by purely combinational control logic. In the same cycle the datapath reads its operands and computes the result, and on the next edge it commits the register write, the memory write and the new program counter together. No pipeline or intermediate stage registers are used. The block executes seven instructions: register add, add-immediate, load-upper-immediate, word load, word store, branch-if-equal and absolute jump.

Instruction and data storage are separate word arrays inside the block. A testbench or boot agent loads both arrays through dedicated write ports while reset is held, then releases reset so that execution starts at address zero. A debug read port returns any general register. A separate flag marks any instruction word the decoder does not recognise. Such a word has no side effect other than the normal advance of the program counter.

Top module: `mono_cycle_cpu`

## Requirements
- R1: While `rst` is high on a rising edge, the program counter and all 32 registers become zero and no instruction takes effect; preload writes to either memory are still accepted.
- R2: When no taken branch or jump applies, the program counter advances by 4 on each edge. This includes unrecognised words.
- R3: Opcode field [31:26] = 0 with function field [5:0] = 32 writes reg[rs] + reg[rt] into reg[rd] (rs = [25:21], rt = [20:16], rd = [15:11]).
- R4: Opcode 8 writes reg[rs] + sign-extended imm[15:0] into reg[rt].
- R5: Opcode 15 writes imm[15:0] placed in bits [31:16] with zero low half into reg[rt].
- R6: Opcode 35 loads the data word at byte address reg[rs] + sign-extended imm into reg[rt].
- R7: Opcode 43 stores reg[rt] to the data word at byte address reg[rs] + sign-extended imm and writes no register.
- R8: Opcode 4 sets PC to PC+4 + (sign-extended imm × 4) when reg[rs] equals reg[rt], and to PC+4 otherwise.
- R9: Opcode 2 sets PC to {bits [31:28] of PC+4, index[25:0], 2'b00}.
- R10: Register 0 always reads as zero, even after an instruction names it as destination.
- R11: Any other opcode/function pair drives `illegal` high while that word is current and writes neither a register nor data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemWe | input | 1 | Instruction memory preload strobe |
| imemAddr | input | IAW | Instruction memory preload word index |
| imemData | input | 32 | Instruction memory preload data |
| dmemWe | input | 1 | Data memory preload strobe |
| dmemAddr | input | DAW | Data memory preload word index |
| dmemData | input | 32 | Data memory preload data |
| dbgRegSel | input | 5 | Register index for debug read |
| dbgRegVal | output | 32 | Contents of the selected register (combinational) |
| pcOut | output | 32 | Current program counter |
| illegal | output | 1 | Current instruction word is unrecognised |

## Verification
Every architectural effect of an instruction appears after exactly one rising edge. The register value, the stored word and the new program counter are all visible from the falling edge that follows the edge at which that word was current. The `illegal` flag is combinational and belongs to the word being fetched, so it is sampled before the edge that retires that word. The bench advances the core one edge at a time and checks at the next falling edge. A store is confirmed by the load that follows it, and skipped or refused writes are confirmed by reading the registers they would have changed.

// File: rtl/mono_pkg.sv
package mono_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_BREQ    = 6'd4;
  localparam logic [5:0] OP_ADDI    = 6'd8;
  localparam logic [5:0] OP_LUI     = 6'd15;
  localparam logic [5:0] OP_LOAD    = 6'd35;
  localparam logic [5:0] OP_STORE   = 6'd43;
  localparam logic [5:0] FN_ADD     = 6'd32;

  typedef struct packed {
    logic regWrite;
    logic dstRd;
    logic aluImm;
    logic memToReg;
    logic memWrite;
    logic luiSel;
    logic branch;
    logic jump;
    logic illegal;
  } ctrl_t;
endpackage

// File: rtl/mono_ctrl.sv
module mono_ctrl
  import mono_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output ctrl_t       ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_ADD) begin
          ctrl.regWrite = 1'b1;
          ctrl.dstRd    = 1'b1;
        end else begin
          ctrl.illegal = 1'b1;
        end
      end
      OP_ADDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.aluImm   = 1'b1;
      end
      OP_LUI: begin
        ctrl.regWrite = 1'b1;
        ctrl.luiSel   = 1'b1;
      end
      OP_LOAD: begin
        ctrl.regWrite = 1'b1;
        ctrl.aluImm   = 1'b1;
        ctrl.memToReg = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluImm   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BREQ: ctrl.branch = 1'b1;
      OP_JUMP: ctrl.jump   = 1'b1;
      default: ctrl.illegal = 1'b1;
    endcase
  end

  // R11: an unrecognised word must not request any state write
  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ctrl.illegal |-> (!ctrl.regWrite && !ctrl.memWrite));

  // R8/R9: at most one kind of flow or store action per word
  p_flow_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.branch, ctrl.jump, ctrl.memWrite, ctrl.regWrite}));
endmodule

// File: rtl/mono_datapath.sv
module mono_datapath
  import mono_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64,
  localparam int unsigned IAW = $clog2(IMEM_WORDS),
  localparam int unsigned DAW = $clog2(DMEM_WORDS),
  localparam int unsigned NREG = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic             imemWe,
  input  logic [IAW-1:0]   imemAddr,
  input  logic [XLEN-1:0]  imemData,
  input  logic             dmemWe,
  input  logic [DAW-1:0]   dmemAddr,
  input  logic [XLEN-1:0]  dmemData,
  input  logic [4:0]       dbgRegSel,
  output logic [XLEN-1:0]  dbgRegVal,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  instr
);
  logic [XLEN-1:0] pcQ;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] regs [NREG];

  logic [4:0]      rsIdx, rtIdx, rdIdx, wbIdx;
  logic [XLEN-1:0] rsVal, rtVal, immSe, aluB, sum, loadVal, wbVal;
  logic [XLEN-1:0] pcPlus4, brTarget, jTarget, pcNext;
  logic            brTaken;

  assign instr   = imem[pcQ[IAW+1:2]];
  assign rsIdx   = instr[25:21];
  assign rtIdx   = instr[20:16];
  assign rdIdx   = instr[15:11];
  assign rsVal   = regs[rsIdx];
  assign rtVal   = regs[rtIdx];
  assign immSe   = {{16{instr[15]}}, instr[15:0]};
  assign aluB    = ctrl.aluImm ? immSe : rtVal;
  assign sum     = rsVal + aluB;
  assign loadVal = dmem[sum[DAW+1:2]];

  always_comb begin
    if (ctrl.luiSel)        wbVal = {instr[15:0], 16'h0000};
    else if (ctrl.memToReg) wbVal = loadVal;
    else                    wbVal = sum;
  end
  assign wbIdx = ctrl.dstRd ? rdIdx : rtIdx;

  assign pcPlus4  = pcQ + 32'd4;
  assign brTarget = pcPlus4 + {immSe[XLEN-3:0], 2'b00};
  assign jTarget  = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign brTaken  = ctrl.branch && (rsVal == rtVal);

  always_comb begin
    if (ctrl.jump)    pcNext = jTarget;
    else if (brTaken) pcNext = brTarget;
    else              pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      pcQ <= pcNext;
      if (ctrl.regWrite && (wbIdx != 5'd0)) regs[wbIdx] <= wbVal;
    end
  end

  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
  end

  always_ff @(posedge clk) begin
    if (dmemWe)                 dmem[dmemAddr] <= dmemData;
    else if (!rst && ctrl.memWrite) dmem[sum[DAW+1:2]] <= rtVal;
  end

  assign dbgRegVal = regs[dbgRegSel];
  assign pcOut     = pcQ;

  // R2: fetch address stays word aligned
  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    pcQ[1:0] == 2'b00);

  // R2: sequential flow when neither branch nor jump is requested
  p_pc_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.branch && !ctrl.jump) |=> pcQ == $past(pcQ) + 32'd4);

  // R10: register zero never holds anything but zero
  p_r0_zero_r10: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

  // R11: an unrecognised word leaves the selected destination unchanged
  p_illegal_nowrite_r11: assert property (@(posedge clk) disable iff (rst)
    ctrl.illegal |=> regs[$past(wbIdx)] == $past(regs[wbIdx]));
endmodule

// File: rtl/mono_cycle_cpu.sv
module mono_cycle_cpu
  import mono_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64,
  localparam int unsigned IAW = $clog2(IMEM_WORDS),
  localparam int unsigned DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imemWe,
  input  logic [IAW-1:0]  imemAddr,
  input  logic [31:0]     imemData,
  input  logic            dmemWe,
  input  logic [DAW-1:0]  dmemAddr,
  input  logic [31:0]     dmemData,
  input  logic [4:0]      dbgRegSel,
  output logic [31:0]     dbgRegVal,
  output logic [31:0]     pcOut,
  output logic            illegal
);
  ctrl_t       ctrl;
  logic [31:0] instr;

  mono_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  mono_datapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .imemWe    (imemWe),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dmemWe    (dmemWe),
    .dmemAddr  (dmemAddr),
    .dmemData  (dmemData),
    .dbgRegSel (dbgRegSel),
    .dbgRegVal (dbgRegVal),
    .pcOut     (pcOut),
    .instr     (instr)
  );

  assign illegal = ctrl.illegal;
endmodule

// File: tb/sim_mono_cycle_cpu.sv
`timescale 1ns/1ps
module sim_mono_cycle_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imemWe = 1'b0;
  logic [5:0]  imemAddr = '0;
  logic [31:0] imemData = '0;
  logic        dmemWe = 1'b0;
  logic [5:0]  dmemAddr = '0;
  logic [31:0] dmemData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [31:0] dbgRegVal, pcOut;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mono_cycle_cpu u0 (
    .clk(clk), .rst(rst),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .dmemWe(dmemWe), .dmemAddr(dmemAddr), .dmemData(dmemData),
    .dbgRegSel(dbgRegSel), .dbgRegVal(dbgRegVal),
    .pcOut(pcOut), .illegal(illegal)
  );

  function automatic logic [31:0] encI(input int op, input int rs, input int rt, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] encJ(input int idx);
    return {6'd2, idx[25:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input int idx, output logic [31:0] val);
    dbgRegSel = idx[4:0];
    #0.5;
    val = dbgRegVal;
  endtask

  task automatic chkReg(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    readReg(idx, v);
    chk(req, v, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadI(input int a, input logic [31:0] w);
    imemWe = 1'b1; imemAddr = a[5:0]; imemData = w;
    step();
    imemWe = 1'b0;
  endtask

  task automatic preload();
    @(negedge clk);
    for (int a = 0; a < 64; a++) loadI(a, 32'hFC00_0000);
    loadI(0,  encI(8, 0, 1, 5));
    loadI(1,  encI(8, 0, 2, -3));
    loadI(2,  encR(1, 2, 3, 32));
    loadI(3,  encI(15, 0, 4, 16'h1234));
    loadI(4,  encI(43, 0, 4, 8));
    loadI(5,  encI(35, 0, 5, 8));
    loadI(6,  encI(35, 1, 6, 7));
    loadI(7,  encI(4, 1, 2, 5));
    loadI(8,  encI(4, 3, 3, 2));
    loadI(9,  encI(8, 0, 7, 1));
    loadI(10, encI(8, 0, 7, 2));
    loadI(11, encI(8, 0, 0, 9));
    loadI(12, 32'hFC00_0000 | (32'd10 << 16) | (32'd10 << 11));
    loadI(13, encJ(16));
    loadI(14, encI(8, 0, 8, 1));
    loadI(15, encI(8, 0, 8, 2));
    loadI(16, encI(8, 0, 9, 16'h7FFF));
    loadI(17, encI(4, 0, 0, -1));
    dmemWe = 1'b1; dmemAddr = 6'd3; dmemData = 32'hCAFE_F00D;
    step();
    dmemWe = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 pc in reset", pcOut, 32'd0);
    chkReg("R1 reg1 in reset", 1, 32'd0);
    chkReg("R1 reg10 in reset", 10, 32'd0);
    rst = 1'b0;
  endtask

  task automatic tArith();
    chk("R11 legal word flag", {31'd0, illegal}, 32'd0);
    step();
    chkReg("R4 addi positive", 1, 32'd5);
    chk("R2 pc after addi", pcOut, 32'd4);
    step();
    chkReg("R4 addi negative sign extend", 2, 32'hFFFF_FFFD);
    step();
    chkReg("R3 add rd", 3, 32'd2);
    chk("R2 pc after add", pcOut, 32'd12);
  endtask

  task automatic tLui();
    step();
    chkReg("R5 lui", 4, 32'h1234_0000);
  endtask

  task automatic tMem();
    step();
    chk("R7 pc after store", pcOut, 32'd20);
    chkReg("R7 store leaves rt", 4, 32'h1234_0000);
    step();
    chkReg("R7 stored word read back", 5, 32'h1234_0000);
    step();
    chkReg("R6 load base plus offset", 6, 32'hCAFE_F00D);
  endtask

  task automatic tBranch();
    step();
    chk("R8 branch not taken", pcOut, 32'd32);
    step();
    chk("R8 branch taken", pcOut, 32'd44);
    chkReg("R8 skipped word", 7, 32'd0);
  endtask

  task automatic tZero();
    step();
    chkReg("R10 reg0 stays zero", 0, 32'd0);
  endtask

  task automatic tIllegal();
    chk("R11 illegal flag", {31'd0, illegal}, 32'd1);
    step();
    chkReg("R11 no write on illegal", 10, 32'd0);
    chk("R2 pc past illegal", pcOut, 32'd52);
  endtask

  task automatic tJump();
    step();
    chk("R9 jump target", pcOut, 32'd64);
    step();
    chkReg("R9 target word ran", 9, 32'h0000_7FFF);
    chkReg("R9 skipped word", 8, 32'd0);
    step();
    chk("R8 backward branch", pcOut, 32'd68);
    step();
    chk("R8 self loop", pcOut, 32'd68);
  endtask

  initial begin
    preload();
    tReset();
    tArith();
    tLui();
    tMem();
    tBranch();
    tZero();
    tIllegal();
    tJump();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule